// File: doc/BRIEF.md
# Burst Column Sequencer

This block walks the column addresses that a synchronous DRAM bank visits during one read or write burst. A start strobe loads an 8-bit start column, a length code and an ordering bit. From the next clock the block presents one column per cycle, together with a valid flag and a flag that marks the final beat.

Fixed bursts of 1, 2, 4 or 8 beats can step in sequential or interleaved order. A full-page burst sweeps the whole 256-column row in sequential order and keeps wrapping until it is told to stop. A terminate strobe, raised for either a burst-stop or a precharge, ends any running burst at once. A new start may arrive on any clock and replaces whatever burst is running.

Top module: `burst_colgen`

## Requirements
- R1: While reset is held (rst_n low) and after its release, until the first start, valid_o and last_o are 0.
- R2: A start_i sampled high at a clock edge makes valid_o high after that edge, with col_o equal to the sampled start_col_i (beat 0). Each further clock advances by one beat.
- R3: The length code len_sel_i[2:0] is captured at start. 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. Any code with bit 2 set gives a full page. A fixed burst delivers exactly its beat count, and valid_o falls on the clock after its last beat.
- R4: Sequential order (ilv_i=0) on a fixed burst of length BL: at beat k the low log2(BL) bits of col_o equal (start + k) mod BL, and the upper bits equal those of the start column.
- R5: Interleaved order (ilv_i=1) on a fixed burst: at beat k, col_o equals the start column XOR k.
- R6: A full-page burst ignores ilv_i. At beat k it presents (start + k) mod 256, and it keeps running past 256 beats until it is terminated or restarted.
- R7: last_o is high exactly on beat BL-1 of a fixed burst and never during a full-page burst.
- R8: term_i sampled high while a burst runs, with start_i low, drops valid_o after that edge. term_i while idle has no effect: valid_o stays low.
- R9: start_i during a running burst abandons it, and the next cycle shows beat 0 of the new burst. When start_i and term_i are high in the same cycle, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 8 | Column of beat 0 |
| len_sel_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Burst-stop or precharge: end the burst |
| col_o | output | 8 | Column for the current beat |
| valid_o | output | 1 | A burst beat is present on col_o |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
A start and a terminate can share a cycle, and so can a start and the final beat of the previous burst. In each case the start must take over and no idle cycle may appear. The bench forces these collisions directly: it raises start and terminate together on a running burst, and it restarts on the exact beat that carries last_o. The random phase then produces them again at random. Every cycle, a bench model that restates the ordering rules arithmetically checks whether the outcome is the new burst's beat 0 or an idle bus.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned LEN_W = 3;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
  parameter int unsigned COL_W = 8
) (
  input  logic [burst_pkg::LEN_W-1:0] code_i,
  output logic [COL_W-1:0]            mask_o,
  output logic                        full_o
);
  assign full_o = code_i[burst_pkg::LEN_W-1];

  // bit i of the mask is set when it lies inside the wrapping window
  for (genvar gi = 0; gi < COL_W; gi++) begin : g_mask
    assign mask_o[gi] = full_o | (gi < int'(code_i[1:0]));
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  burst_pkg::order_e ord_i,
  output logic [COL_W-1:0] col_o
);
  import burst_pkg::*;

  function automatic logic [COL_W-1:0] seq_col(
    input logic [COL_W-1:0] base, input logic [COL_W-1:0] beat,
    input logic [COL_W-1:0] mask);
    logic [COL_W-1:0] sum;
    sum = base + beat;
    return (base & ~mask) | (sum & mask);
  endfunction

  function automatic logic [COL_W-1:0] ilv_col(
    input logic [COL_W-1:0] base, input logic [COL_W-1:0] beat,
    input logic [COL_W-1:0] mask);
    return base ^ (beat & mask);
  endfunction

  always_comb begin
    if (ord_i == ORD_ILV) col_o = ilv_col(base_i, beat_i, mask_i);
    else                  col_o = seq_col(base_i, beat_i, mask_i);
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int unsigned COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              term_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [COL_W-1:0]  mask_i,
  input  logic              full_i,
  input  logic              ilv_i,
  output logic              active_o,
  output logic [COL_W-1:0]  beat_o,
  output logic [COL_W-1:0]  base_o,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o,
  output burst_pkg::order_e ord_o,
  output logic              last_o,
  output logic              adv_o
);
  import burst_pkg::*;

  logic              active_q;
  logic [COL_W-1:0]  beat_q;
  logic [COL_W-1:0]  base_q;
  logic [COL_W-1:0]  mask_q;
  logic              full_q;
  order_e            ord_q;
  logic              last_w;
  logic              stop_w;

  assign last_w = active_q & ~full_q & (beat_q == mask_q);
  assign stop_w = term_i | last_w;
  assign adv_o  = active_q & ~start_i & ~stop_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ord_q    <= ORD_SEQ;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= col_i;
      mask_q   <= mask_i;
      full_q   <= full_i;
      ord_q    <= (ilv_i & ~full_i) ? ORD_ILV : ORD_SEQ;
    end else if (active_q) begin
      if (stop_w) active_q <= 1'b0;
      else        beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign full_o   = full_q;
  assign ord_o    = ord_q;
  assign last_o   = last_w;
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int unsigned COL_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [COL_W-1:0]            start_col_i,
  input  logic [burst_pkg::LEN_W-1:0] len_sel_i,
  input  logic                        ilv_i,
  input  logic                        term_i,
  output logic [COL_W-1:0]            col_o,
  output logic                        valid_o,
  output logic                        last_o
);
  import burst_pkg::*;

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic [COL_W-1:0] beat_w;
  logic [COL_W-1:0] base_w;
  logic [COL_W-1:0] mask_w;
  logic             full_w;
  order_e           ord_w;
  logic             ev_adv;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (len_sel_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .term_i   (term_i),
    .col_i    (start_col_i),
    .mask_i   (dec_mask),
    .full_i   (dec_full),
    .ilv_i    (ilv_i),
    .active_o (valid_o),
    .beat_o   (beat_w),
    .base_o   (base_w),
    .mask_o   (mask_w),
    .full_o   (full_w),
    .ord_o    (ord_w),
    .last_o   (last_o),
    .adv_o    (ev_adv)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i (base_w),
    .beat_i (beat_w),
    .mask_i (mask_w),
    .ord_i  (ord_w),
    .col_o  (col_o)
  );
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic [COL_W-1:0] mask_w,
  input logic             full_w,
  input logic             ev_adv
);
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_adv |=> ((col_o & ~mask_w) == ($past(col_o) & ~$past(mask_w))));

  p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_adv && full_w) |=> (col_o == COL_W'($past(col_o) + 1'b1)));

  p_last_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (valid_o && !full_w));

  p_term_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && !start_i) |=> !valid_o);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> !valid_o);
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .mask_w      (mask_w),
  .full_w      (full_w),
  .ev_adv      (ev_adv)
);

// File: tb/sim_burst_colgen.sv
`timescale 1ns/1ps
module sim_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] start_col_i;
  logic [2:0] len_sel_i;
  logic       ilv_i;
  logic       term_i;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;

  always #2.5 clk = ~clk;

  burst_colgen u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_sel_i(len_sel_i), .ilv_i(ilv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_v = 0, m_base = 0, m_k = 0, m_bl = 1, m_full = 0, m_ilv = 0;

  function automatic int exp_col();
    if (m_full) return (m_base + m_k) % 256;
    if (m_ilv)  return m_base ^ m_k;
    return (m_base / m_bl) * m_bl + ((m_base % m_bl + m_k) % m_bl);
  endfunction

  function automatic string auto_tag();
    if (!m_v)   return "R3";
    if (m_full) return "R6";
    if (m_ilv)  return "R5";
    return "R4";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input int c, input int code, input bit il,
                      input bit t, input string tag);
    string use_tag;
    @(negedge clk);
    start_i = s; start_col_i = 8'(c); len_sel_i = 3'(code); ilv_i = il; term_i = t;
    if (s) begin
      m_v = 1; m_base = c; m_k = 0;
      m_full = (code >> 2) & 1;
      m_bl = m_full ? 256 : (1 << (code & 3));
      m_ilv = il && !m_full;
    end else if (m_v) begin
      if (t || (!m_full && m_k == m_bl - 1)) m_v = 0;
      else m_k = (m_k + 1) % 256;
    end
    use_tag = (tag != "") ? tag : auto_tag();
    @(posedge clk); #1;
    chk(use_tag, "valid", int'(valid_o), m_v);
    if (m_v) chk(use_tag, "col", int'(col_o), exp_col());
    chk("R7", "last", int'(last_o), (m_v && !m_full && m_k == m_bl - 1) ? 1 : 0);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    int v;
    seed = 32'h5eed_c01;
    v = $urandom(seed);
    rst_n = 1'b0; start_i = 0; start_col_i = 0; len_sel_i = 0; ilv_i = 0; term_i = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "valid_in_reset", int'(valid_o), 0);
    chk("R1", "last_in_reset", int'(last_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "valid_after_reset", int'(valid_o), 0);
    chk("R1", "last_after_reset", int'(last_o), 0);

    // R2 R3 R4 R5 R7: every start offset, every fixed length, both orders
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int c = 0; c < 256; c++) begin
          step(1, c, code, il[0], 0, "R2");
          idle(1 << code, "");
        end

    // R6: full page ignores ilv, wraps past 256, runs until terminated (R8)
    step(1, 250, 7, 1, 0, "R6");
    idle(300, "R6");
    step(0, 0, 0, 0, 1, "R8");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "R8");
    for (int code = 4; code < 7; code++) begin
      step(1, code * 37, code, code[0], 0, "R3");
      idle(9, "R6");
      step(0, 0, 0, 0, 1, "R8");
    end

    // R8: terminate mid fixed burst
    step(1, 13, 3, 0, 0, "R2");
    idle(2, "R4");
    step(0, 0, 0, 0, 1, "R8");
    idle(2, "R8");

    // R9: preempt, start+term same cycle, restart on last beat, back to back
    step(1, 10, 3, 0, 0, "R2");
    idle(3, "R4");
    step(1, 77, 2, 1, 0, "R9");
    step(1, 200, 3, 1, 1, "R9");
    idle(6, "R5");
    step(1, 99, 1, 0, 0, "R9");
    for (int i = 0; i < 20; i++) step(1, i * 13, i % 5, i[0], i[1], "R9");
    idle(10, "");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit s, t, il;
      int c, code;
      s = ($urandom % 6) == 0;
      t = ($urandom % 10) == 0;
      il = $urandom % 2;
      c = $urandom % 256;
      code = $urandom % 8;
      step(s, c, code, il, t, "");
    end
    idle(10, "");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule